// File: doc/BRIEF.md
# Grid-Based Convergence Correction Sequencer

This block produces two digital correction streams, one for horizontal (X) misregistration and one for vertical (Y) misregistration, for a raster display. The visible area is split into a fixed grid of cells, 11 rows by 15 columns by default, and every cell owns one correction word per channel. Each word drives a resistor-ladder DAC, so it leaves the block as a parallel binary value.

After reset the block reads every correction word, one byte at a time, from a nonvolatile store through a simple request/acknowledge byte port. It writes the words into a local two-channel cell RAM. While this copy runs, the block keeps its mute output high and holds both DAC words at zero. Once the copy is done, it follows the raster. A column position advances at equal clock-counted slices of each line. A row position advances after a fixed number of lines. The words of the current cell appear on the two DAC outputs.

The degauss input forces the mute output high and the DAC words to zero for as long as it is held. Raster tracking continues underneath, so correction resumes at the right cell when degauss is released.

Top module: `conv_grid_seq`

## Requirements
- R1: While reset is asserted, mute_o is 1 and both DAC outputs are 8'h00.
- R2: The loader reads store addresses 0 to 2*ROWS*COLS-1 in ascending order, exactly once each. It keeps nv_req_o high and nv_addr_o stable until nv_ack_i is seen. The byte at address row*COLS+col is the X word of that cell, and the byte at ROWS*COLS+row*COLS+col is its Y word.
- R3: While the load is in progress, mute_o is 1 and both DAC outputs are 8'h00. Within two clocks of the last acknowledged byte, mute_o falls if degauss_i is low.
- R4: A rising edge of hsync_i returns the column to 0. The column then advances by one every COL_CYCLES clocks. The DAC words follow the column one clock after it changes.
- R5: The column stops at COLS-1 and stays there until the next hsync_i rising edge.
- R6: The row advances by one after every ROW_LINES hsync_i rising edges and stops at ROWS-1. A rising edge of vsync_i returns the row and the line count to 0 and takes priority over an hsync_i edge in the same clock.
- R7: With mute_o low, dac_x_o and dac_y_o carry the X and Y words of the current cell. Each word is 8-bit two's complement, and 8'h00 means no correction.
- R8: While degauss_i is high, mute_o is 1 and both DAC outputs are 8'h00 from the next clock on. Row and column tracking continue, so the correct cell's words reappear after release.
- R9: An hsync_i pulse held high for several clocks counts as one line and resets the column only at its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_i | input | 1 | Horizontal flyback pulse, active high |
| vsync_i | input | 1 | Vertical pump pulse, active high |
| degauss_i | input | 1 | High while degauss runs |
| nv_req_o | output | 1 | Byte read request to the nonvolatile store |
| nv_addr_o | output | NV_AW (9) | Byte address of the pending read |
| nv_ack_i | input | 1 | Store returns nv_data_i in this cycle |
| nv_data_i | input | WORD_W (8) | Byte returned by the store |
| dac_x_o | output | WORD_W (8) | Horizontal correction word to the ladder DAC |
| dac_y_o | output | WORD_W (8) | Vertical correction word to the ladder DAC |
| mute_o | output | 1 | Stops correction current when high |

## Verification
The bench keeps the full 11 by 15 grid, so it checks every one of the 330 store addresses and every cell-to-address mapping at the default size. It shrinks COL_CYCLES to 4 and ROW_LINES to 2. A line is then 64 clocks and a field 22 lines. This brings column saturation at the end of a line, row saturation after the last row, vsync priority, mid-field restarts, degauss windows and stretched hsync pulses within a few thousand cycles.

// File: rtl/conv_grid_pkg.sv
// Shared types of the convergence correction sequencer.
// Assumes two correction channels, X then Y, in the nonvolatile store.
package conv_grid_pkg;

    // Number of correction channels (X and Y)
    localparam int CHANNELS = 2;

    // Channel selector for cell RAM writes
    typedef enum logic {
        CH_X = 1'b0,
        CH_Y = 1'b1
    } chan_e;

    // Boot loader progress
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_FETCH = 2'd1,
        LD_DONE  = 2'd2
    } load_state_e;

endpackage

// File: rtl/conv_nv_loader.sv
// Copies all correction bytes from the nonvolatile store into the cell RAM
// after reset. Bytes 0..CELLS-1 are X words, CELLS..2*CELLS-1 are Y words.
// Assumes the store answers each request with a one-cycle acknowledge
// carrying the byte; request and address stay put until then.
module conv_nv_loader
    import conv_grid_pkg::*;
#(
    parameter int CELLS  = 165,
    parameter int WORD_W = 8,
    parameter int NV_AW  = $clog2(2 * CELLS),
    localparam int CELL_W = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              nv_req_o,
    output logic [NV_AW-1:0]  nv_addr_o,
    input  logic              nv_ack_i,
    input  logic [WORD_W-1:0] nv_data_i,
    output logic              loading_o,
    output logic              wr_en_o,
    output chan_e             wr_ch_o,
    output logic [CELL_W-1:0] wr_cell_o,
    output logic [WORD_W-1:0] wr_data_o
);

    localparam logic [NV_AW-1:0] LAST_ADDR  = NV_AW'(2 * CELLS - 1);
    localparam logic [NV_AW-1:0] CELLS_ADDR = NV_AW'(CELLS);

    load_state_e      state_q;
    logic [NV_AW-1:0] idx_q;
    logic [NV_AW-1:0] cell_wide;

    // Sequence the load: idle one cycle after reset, fetch all bytes, done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                LD_IDLE:  state_q <= LD_FETCH;
                LD_FETCH: begin
                    if (nv_ack_i) begin
                        if (idx_q == LAST_ADDR) begin
                            state_q <= LD_DONE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default:  state_q <= LD_DONE;
            endcase
        end
    end

    // Split the store address into channel and cell index
    always_comb begin
        if (idx_q >= CELLS_ADDR) begin
            wr_ch_o   = CH_Y;
            cell_wide = idx_q - CELLS_ADDR;
        end else begin
            wr_ch_o   = CH_X;
            cell_wide = idx_q;
        end
    end

    assign wr_cell_o = CELL_W'(cell_wide);
    assign wr_data_o = nv_data_i;
    assign wr_en_o   = (state_q == LD_FETCH) && nv_ack_i;
    assign nv_req_o  = (state_q == LD_FETCH);
    assign nv_addr_o = idx_q;
    assign loading_o = (state_q != LD_DONE);

endmodule

// File: rtl/conv_raster_track.sv
// Follows the raster and reports the grid cell under the beam.
// Column: cleared on an hsync rising edge, then stepped every COL_CYCLES
// clocks, holding at the last column. Row: stepped every ROW_LINES hsync
// edges, holding at the last row, cleared on a vsync rising edge.
// Assumes sync inputs are already synchronous to clk.
module conv_raster_track #(
    parameter int ROWS       = 11,
    parameter int COLS       = 15,
    parameter int COL_CYCLES = 64,
    parameter int ROW_LINES  = 24,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_i,
    input  logic             vsync_i,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o
);

    localparam int CC_W = (COL_CYCLES > 1) ? $clog2(COL_CYCLES) : 1;
    localparam int LN_W = (ROW_LINES > 1) ? $clog2(ROW_LINES) : 1;
    localparam logic [CC_W-1:0]  CC_LAST  = CC_W'(COL_CYCLES - 1);
    localparam logic [LN_W-1:0]  LN_LAST  = LN_W'(ROW_LINES - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    logic            hs_q, vs_q;
    logic            hs_edge, vs_edge;
    logic [CC_W-1:0] cyc_q;
    logic [LN_W-1:0] line_q;

    // Remember last sync levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            hs_q <= hsync_i;
            vs_q <= vsync_i;
        end
    end

    assign hs_edge = hsync_i && !hs_q;
    assign vs_edge = vsync_i && !vs_q;

    // Step the column across the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
            col_o <= '0;
        end else if (hs_edge || vs_edge) begin
            cyc_q <= '0;
            col_o <= '0;
        end else if (cyc_q == CC_LAST) begin
            cyc_q <= '0;
            if (col_o != COL_LAST) begin
                col_o <= col_o + 1'b1;
            end
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // Step the row down the field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            row_o  <= '0;
        end else if (vs_edge) begin
            line_q <= '0;
            row_o  <= '0;
        end else if (hs_edge) begin
            if (line_q == LN_LAST) begin
                line_q <= '0;
                if (row_o != ROW_LAST) begin
                    row_o <= row_o + 1'b1;
                end
            end else begin
                line_q <= line_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/conv_cell_ram.sv
// Per-channel correction word storage, one word per grid cell.
// One write port shared by the channels, and a read port per channel
// with combinational read. Contents are undefined until loaded.
module conv_cell_ram
    import conv_grid_pkg::*;
#(
    parameter int CELLS  = 165,
    parameter int WORD_W = 8,
    localparam int CELL_W = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  chan_e             wr_ch_i,
    input  logic [CELL_W-1:0] wr_cell_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [CELL_W-1:0] rd_cell_i,
    output logic [WORD_W-1:0] rd_x_o,
    output logic [WORD_W-1:0] rd_y_o
);

    logic [WORD_W-1:0] rd_word [CHANNELS];

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        logic [WORD_W-1:0] mem [CELLS];

        // Store a loaded word into this channel's array
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_ch_i == chan_e'(ch))) begin
                mem[wr_cell_i] <= wr_data_i;
            end
        end

        assign rd_word[ch] = mem[rd_cell_i];
    end

    assign rd_x_o = rd_word[CH_X];
    assign rd_y_o = rd_word[CH_Y];

endmodule

// File: rtl/conv_grid_seq.sv
// Top of the convergence correction sequencer. Loads the cell table from
// the nonvolatile store, then presents the current cell's X and Y words to
// the ladder DACs, forced to zero with mute high during load or degauss.
// Assumes COL_CYCLES*COLS fits in one line and sync inputs are synchronous.
module conv_grid_seq
    import conv_grid_pkg::*;
#(
    parameter int ROWS       = 11,
    parameter int COLS       = 15,
    parameter int WORD_W     = 8,
    parameter int COL_CYCLES = 64,
    parameter int ROW_LINES  = 24,
    localparam int CELLS  = ROWS * COLS,
    localparam int NV_AW  = $clog2(2 * CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic              degauss_i,
    output logic              nv_req_o,
    output logic [NV_AW-1:0]  nv_addr_o,
    input  logic              nv_ack_i,
    input  logic [WORD_W-1:0] nv_data_i,
    output logic [WORD_W-1:0] dac_x_o,
    output logic [WORD_W-1:0] dac_y_o,
    output logic              mute_o
);

    localparam int CELL_W = $clog2(CELLS);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int COL_W  = $clog2(COLS);

    logic              loading;
    logic              wr_en;
    chan_e             wr_ch;
    logic [CELL_W-1:0] wr_cell;
    logic [WORD_W-1:0] wr_data;
    logic [ROW_W-1:0]  cur_row;
    logic [COL_W-1:0]  cur_col;
    logic [CELL_W-1:0] rd_cell;
    logic [WORD_W-1:0] rd_x, rd_y;
    logic              quiet;

    conv_nv_loader #(
        .CELLS  (CELLS),
        .WORD_W (WORD_W),
        .NV_AW  (NV_AW)
    ) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .nv_req_o  (nv_req_o),
        .nv_addr_o (nv_addr_o),
        .nv_ack_i  (nv_ack_i),
        .nv_data_i (nv_data_i),
        .loading_o (loading),
        .wr_en_o   (wr_en),
        .wr_ch_o   (wr_ch),
        .wr_cell_o (wr_cell),
        .wr_data_o (wr_data)
    );

    conv_raster_track #(
        .ROWS       (ROWS),
        .COLS       (COLS),
        .COL_CYCLES (COL_CYCLES),
        .ROW_LINES  (ROW_LINES)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .hsync_i (hsync_i),
        .vsync_i (vsync_i),
        .row_o   (cur_row),
        .col_o   (cur_col)
    );

    assign rd_cell = CELL_W'(cur_row) * CELL_W'(COLS) + CELL_W'(cur_col);

    conv_cell_ram #(
        .CELLS  (CELLS),
        .WORD_W (WORD_W)
    ) u_ram (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_ch_i   (wr_ch),
        .wr_cell_i (wr_cell),
        .wr_data_i (wr_data),
        .rd_cell_i (rd_cell),
        .rd_x_o    (rd_x),
        .rd_y_o    (rd_y)
    );

    assign quiet = loading || degauss_i;

    // Register DAC words and mute, zeroing the words while quiet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mute_o  <= 1'b1;
            dac_x_o <= '0;
            dac_y_o <= '0;
        end else begin
            mute_o  <= quiet;
            dac_x_o <= quiet ? '0 : rd_x;
            dac_y_o <= quiet ? '0 : rd_y;
        end
    end

endmodule

// File: rtl/conv_grid_chk.sv
// Property checker for the convergence correction sequencer, bound to the
// top. Observes ports plus the loader status and the raster position.
module conv_grid_chk #(
    parameter int ROWS   = 11,
    parameter int COLS   = 15,
    parameter int WORD_W = 8,
    parameter int NV_AW  = 9,
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hsync_i,
    input logic              vsync_i,
    input logic              nv_req_o,
    input logic              nv_ack_i,
    input logic [NV_AW-1:0]  nv_addr_o,
    input logic              loading,
    input logic              mute_o,
    input logic [WORD_W-1:0] dac_x_o,
    input logic [WORD_W-1:0] dac_y_o,
    input logic [ROW_W-1:0]  cur_row,
    input logic [COL_W-1:0]  cur_col
);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_req_o && !nv_ack_i) |=> (nv_req_o && $stable(nv_addr_o)));

    // R3
    load_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loading |=> mute_o);

    // R3
    muted_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_o |-> (dac_x_o == '0 && dac_y_o == '0));

    // R4
    col_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_i) |=> (cur_col == '0));

    // R5
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_col <= COL_W'(COLS - 1));

    // R6
    row_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_i) |=> (cur_row == '0));

    // R6
    row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_row <= ROW_W'(ROWS - 1));

endmodule

bind conv_grid_seq conv_grid_chk #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .WORD_W (WORD_W),
    .NV_AW  (NV_AW),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync_i   (hsync_i),
    .vsync_i   (vsync_i),
    .nv_req_o  (nv_req_o),
    .nv_ack_i  (nv_ack_i),
    .nv_addr_o (nv_addr_o),
    .loading   (loading),
    .mute_o    (mute_o),
    .dac_x_o   (dac_x_o),
    .dac_y_o   (dac_y_o),
    .cur_row   (cur_row),
    .cur_col   (cur_col)
);

// File: tb/conv_grid_seq_test.sv
`timescale 1ns/1ps
// Directed bench for the convergence correction sequencer.
module conv_grid_seq_test;

    localparam int ROWS       = 11;
    localparam int COLS       = 15;
    localparam int WORD_W     = 8;
    localparam int COL_CYCLES = 4;
    localparam int ROW_LINES  = 2;
    localparam int CELLS      = ROWS * COLS;
    localparam int NV_AW      = $clog2(2 * CELLS);
    localparam int LINE       = COL_CYCLES * COLS + 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hsync = 1'b0;
    logic              vsync = 1'b0;
    logic              degauss = 1'b0;
    logic              nv_req;
    logic [NV_AW-1:0]  nv_addr;
    logic              nv_ack = 1'b0;
    logic [WORD_W-1:0] nv_data = '0;
    logic [WORD_W-1:0] dac_x, dac_y;
    logic              mute;

    int vectors = 0;
    int errors  = 0;
    int served  = 0;

    always #4 clk = ~clk;

    conv_grid_seq #(
        .ROWS       (ROWS),
        .COLS       (COLS),
        .WORD_W     (WORD_W),
        .COL_CYCLES (COL_CYCLES),
        .ROW_LINES  (ROW_LINES)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync_i   (hsync),
        .vsync_i   (vsync),
        .degauss_i (degauss),
        .nv_req_o  (nv_req),
        .nv_addr_o (nv_addr),
        .nv_ack_i  (nv_ack),
        .nv_data_i (nv_data),
        .dac_x_o   (dac_x),
        .dac_y_o   (dac_y),
        .mute_o    (mute)
    );

    function automatic logic [7:0] nv_byte(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    function automatic logic [7:0] exp_word(input int ch, input int r, input int c);
        return nv_byte(ch * CELLS + r * COLS + c);
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic check_cell(input int r, input int c, input bit muted, input string tag);
        check({tag, " dac_x"}, int'(dac_x), muted ? 0 : int'(exp_word(0, r, c)));
        check({tag, " dac_y"}, int'(dac_y), muted ? 0 : int'(exp_word(1, r, c)));
        check({tag, " mute"},  int'(mute),  int'(muted));
    endtask

    // One line of LINE clocks, entered and left at a falling edge
    task automatic run_line(input bit vs, input bit wide, input int row,
                            input bit muted, input string tag);
        hsync = 1'b1;
        vsync = vs;
        @(negedge clk);
        if (!wide) hsync = 1'b0;
        vsync = 1'b0;
        repeat (2) @(negedge clk);
        hsync = 1'b0;
        for (int c = 0; c < COLS; c++) begin
            if (c > 0) repeat (COL_CYCLES) @(negedge clk);
            check_cell(row, c, muted, tag);
        end
        repeat (COL_CYCLES) @(negedge clk);
        check_cell(row, COLS - 1, muted, "R5 hold");
        repeat (LINE - 3 - COL_CYCLES * COLS) @(negedge clk);
    endtask

    function automatic int row_of(input int ln);
        return (ln / ROW_LINES < ROWS) ? ln / ROW_LINES : ROWS - 1;
    endfunction

    // Store model: answers each request one falling edge later, checks order (R2)
    initial begin
        int exp_idx = 0;
        wait (rst_n);
        forever begin
            @(negedge clk);
            nv_ack = 1'b0;
            if (nv_req) begin
                @(negedge clk);
                check("R2 nv_addr", int'(nv_addr), exp_idx);
                nv_data = nv_byte(int'(nv_addr));
                nv_ack  = 1'b1;
                exp_idx++;
                served++;
            end
        end
    end

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 mute", int'(mute), 1);
        check("R1 dac_x", int'(dac_x), 0);
        check("R1 dac_y", int'(dac_y), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_boot;
        repeat (20) @(negedge clk);
        check("R3 req", int'(nv_req), 1);
        check("R3 mute", int'(mute), 1);
        check("R3 dac_x", int'(dac_x), 0);
        check("R3 dac_y", int'(dac_y), 0);
        while (nv_req) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R3 unmute", int'(mute), 0);
        check("R2 bytes", served, 2 * CELLS);
    endtask

    task automatic t_partial_field;
        for (int ln = 0; ln < 5; ln++)
            run_line(ln == 0, 1'b0, row_of(ln), 1'b0, "R4 R7");
    endtask

    task automatic t_full_field;
        for (int ln = 0; ln < ROWS * ROW_LINES + 2; ln++)
            run_line(ln == 0, 1'b0, row_of(ln), 1'b0, "R6 R7");
    endtask

    task automatic t_degauss;
        for (int ln = 0; ln < 6; ln++) begin
            degauss = (ln == 2 || ln == 3);
            run_line(ln == 0, 1'b0, row_of(ln), degauss, "R8");
        end
        degauss = 1'b0;
    endtask

    task automatic t_wide_hsync;
        for (int ln = 0; ln < 7; ln++)
            run_line(ln == 0, ln > 0, row_of(ln), 1'b0, "R9");
    endtask

    initial begin
        t_reset();
        t_boot();
        @(negedge clk);
        t_partial_field();
        t_full_field();
        t_degauss();
        t_wide_hsync();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule